// File: doc/BRIEF.md
# Banked GPIO Pin Register File

This block is the register core of a general-purpose I/O controller. It serves 128 pins, arranged as four banks of 32. Software reaches the pins through a simple register port: an address, a write strobe, write data, and read data that arrives one cycle later.

Each bank has its own set of registers:
- A direction word.
- An output latch. Software cannot write the latch directly; it only changes through a write-one-to-set register and a write-one-to-clear register.
- A level view. On a read, each bit comes from the output latch if that pin is an output, or from the synchronized input pin if it is an input.
- Two 32-bit alternate-function words. Logic outside the block decodes these.

The first three banks of the level, direction, set and clear registers sit at contiguous offsets. The fourth bank of each of those registers is placed in an upper window at 0x100 plus the bank-0 offset. The alternate-function words form an interleaved low/high run.

On the pin side the block drives one output value and one output enable per pin. It samples the raw pin inputs through a two-stage synchronizer. Edge detection, interrupts and pad circuitry belong to other blocks.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After reset, every register reads zero and `pin_oe` and `pin_out` are all zero, so every pin is an input.
- R2: The level register of banks 0..3 is at byte offsets 0x000, 0x004, 0x008, 0x100. The direction register is at 0x00C, 0x010, 0x014, 0x10C. Reading a direction register returns the last value written to it.
- R3: Output-set is at 0x018, 0x01C, 0x020, 0x118. Output-clear is at 0x024, 0x028, 0x02C, 0x124. A set write ORs the data into the bank latch. A clear write clears each latch bit where the data has a 1.
- R4: Alternate-function low is at 0x054, 0x05C, 0x064, 0x06C and high is at 0x058, 0x060, 0x068, 0x070 for banks 0..3. Each stores and returns a full 32-bit word.
- R5: A direction bit of 1 makes pin b*32+i an output. `pin_oe` equals the direction word and `pin_out` equals latch AND direction, so an input pin drives 0. Both change only on a register write.
- R6: Each level bit reads the latch bit when the direction bit is 1 and the synchronized input bit when it is 0.
- R7: Inputs pass through two flops. With the level address held, a change on `pin_in` first shows in `reg_rdata` after the third rising edge.
- R8: Reads of any set or clear address return zero.
- R9: Unmapped or misaligned offsets (for example 0x030, 0x074, 0x00E) read zero, and writes to them change no register and no pin.
- R10: `reg_rdata` is registered from the address present at a rising edge. A read issued in the same cycle as a write to that register returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the offset presented one cycle earlier |
| pin_in | input | 128 | Raw pin inputs, bank b at bits b*32 +: 32 |
| pin_out | output | 128 | Value driven on each pin |
| pin_oe | output | 128 | Output enable per pin |

## Verification
Timing of each result after its stimulus:

| Result | Due |
|---|---|
| `pin_oe` and `pin_out` | Right after the write edge |
| Register read data | Right after the edge that samples the address |
| Input pin change in a level read | Only after three edges |

The bench drives every input at a falling edge and samples one falling edge after the capturing rising edge. After each pin change it waits three rising edges before any level read. One directed case holds the level address while the pin flips: it expects the old value after the second edge and the new one after the third. Another places a read under a write to the same register in one cycle and expects the pre-write value.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;
  localparam int GPIO_BANKS   = 4;
  localparam int BANK_PINS    = 32;
  localparam int REG_ADDR_W   = 12;
  localparam int BANK_IDX_W   = $clog2(GPIO_BANKS);

  typedef enum logic [2:0] {
    RK_NONE,
    RK_LEVEL,
    RK_DIR,
    RK_SET,
    RK_CLR,
    RK_AF_LO,
    RK_AF_HI
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e               kind;
    logic [BANK_IDX_W-1:0]   bank;
  } reg_sel_t;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_rf_pkg::*;
(
  input  logic [REG_ADDR_W-1:0] addr,
  output reg_sel_t              sel
);
  always_comb begin
    sel.kind = RK_NONE;
    sel.bank = '0;
    case (addr)
      12'h000: begin sel.kind = RK_LEVEL; sel.bank = 2'd0; end
      12'h004: begin sel.kind = RK_LEVEL; sel.bank = 2'd1; end
      12'h008: begin sel.kind = RK_LEVEL; sel.bank = 2'd2; end
      12'h100: begin sel.kind = RK_LEVEL; sel.bank = 2'd3; end
      12'h00C: begin sel.kind = RK_DIR;   sel.bank = 2'd0; end
      12'h010: begin sel.kind = RK_DIR;   sel.bank = 2'd1; end
      12'h014: begin sel.kind = RK_DIR;   sel.bank = 2'd2; end
      12'h10C: begin sel.kind = RK_DIR;   sel.bank = 2'd3; end
      12'h018: begin sel.kind = RK_SET;   sel.bank = 2'd0; end
      12'h01C: begin sel.kind = RK_SET;   sel.bank = 2'd1; end
      12'h020: begin sel.kind = RK_SET;   sel.bank = 2'd2; end
      12'h118: begin sel.kind = RK_SET;   sel.bank = 2'd3; end
      12'h024: begin sel.kind = RK_CLR;   sel.bank = 2'd0; end
      12'h028: begin sel.kind = RK_CLR;   sel.bank = 2'd1; end
      12'h02C: begin sel.kind = RK_CLR;   sel.bank = 2'd2; end
      12'h124: begin sel.kind = RK_CLR;   sel.bank = 2'd3; end
      12'h054: begin sel.kind = RK_AF_LO; sel.bank = 2'd0; end
      12'h05C: begin sel.kind = RK_AF_LO; sel.bank = 2'd1; end
      12'h064: begin sel.kind = RK_AF_LO; sel.bank = 2'd2; end
      12'h06C: begin sel.kind = RK_AF_LO; sel.bank = 2'd3; end
      12'h058: begin sel.kind = RK_AF_HI; sel.bank = 2'd0; end
      12'h060: begin sel.kind = RK_AF_HI; sel.bank = 2'd1; end
      12'h068: begin sel.kind = RK_AF_HI; sel.bank = 2'd2; end
      12'h070: begin sel.kind = RK_AF_HI; sel.bank = 2'd3; end
      default: begin sel.kind = RK_NONE;  sel.bank = '0;   end
    endcase
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_rf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_kind_e    kind,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] sync_in,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] aflo_q,
  output logic [W-1:0] afhi_q,
  output logic [W-1:0] level
);
  logic         dir_en, lat_en, aflo_en, afhi_en;
  logic [W-1:0] lat_d;

  always_comb begin
    dir_en  = wr_en && (kind == RK_DIR);
    lat_en  = wr_en && ((kind == RK_SET) || (kind == RK_CLR));
    aflo_en = wr_en && (kind == RK_AF_LO);
    afhi_en = wr_en && (kind == RK_AF_HI);
    lat_d   = (kind == RK_SET) ? (lat_q | wdata) : (lat_q & ~wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      lat_q  <= '0;
      aflo_q <= '0;
      afhi_q <= '0;
    end else begin
      if (dir_en)  dir_q  <= wdata;
      if (lat_en)  lat_q  <= lat_d;
      if (aflo_en) aflo_q <= wdata;
      if (afhi_en) afhi_q <= wdata;
    end
  end

  assign level = (lat_q & dir_q) | (sync_in & ~dir_q);
endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_rf_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [REG_ADDR_W-1:0]            reg_addr,
  input  logic                             reg_wr,
  input  logic [BANK_PINS-1:0]             reg_wdata,
  output logic [BANK_PINS-1:0]             reg_rdata,
  input  logic [GPIO_BANKS*BANK_PINS-1:0]  pin_in,
  output logic [GPIO_BANKS*BANK_PINS-1:0]  pin_out,
  output logic [GPIO_BANKS*BANK_PINS-1:0]  pin_oe
);
  localparam int W     = BANK_PINS;
  localparam int NPINS = GPIO_BANKS * BANK_PINS;

  reg_sel_t       sel;
  logic [NPINS-1:0] pin_sync;
  logic [W-1:0]   dir_a   [GPIO_BANKS];
  logic [W-1:0]   lat_a   [GPIO_BANKS];
  logic [W-1:0]   aflo_a  [GPIO_BANKS];
  logic [W-1:0]   afhi_a  [GPIO_BANKS];
  logic [W-1:0]   level_a [GPIO_BANKS];
  logic [W-1:0]   rdata_d;
  logic [W-1:0]   rdata_q;

  gpio_addr_decode u_dec (
    .addr (reg_addr),
    .sel  (sel)
  );

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  for (genvar b = 0; b < GPIO_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = reg_wr && (sel.bank == BANK_IDX_W'(b));

    gpio_bank #(.W(W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_wr),
      .kind    (sel.kind),
      .wdata   (reg_wdata),
      .sync_in (pin_sync[b*W +: W]),
      .dir_q   (dir_a[b]),
      .lat_q   (lat_a[b]),
      .aflo_q  (aflo_a[b]),
      .afhi_q  (afhi_a[b]),
      .level   (level_a[b])
    );

    assign pin_oe[b*W +: W]  = dir_a[b];
    assign pin_out[b*W +: W] = lat_a[b] & dir_a[b];
  end

  always_comb begin
    case (sel.kind)
      RK_LEVEL: rdata_d = level_a[sel.bank];
      RK_DIR:   rdata_d = dir_a[sel.bank];
      RK_AF_LO: rdata_d = aflo_a[sel.bank];
      RK_AF_HI: rdata_d = afhi_a[sel.bank];
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/gpio_bank_regfile_chk.sv
module gpio_bank_regfile_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [11:0]  reg_addr,
  input logic         reg_wr,
  input logic [31:0]  reg_wdata,
  input logic [31:0]  reg_rdata,
  input logic [127:0] pin_out,
  input logic [127:0] pin_oe
);
  AST_DIR_UPPER_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 12'h10C |=> pin_oe[127:96] == $past(reg_wdata)); // R2

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 12'h018 |=>
      ((pin_out[31:0] ^ pin_oe[31:0]) & $past(reg_wdata)) == 32'h0); // R3

  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 12'h124 |=> (pin_out[127:96] & $past(reg_wdata)) == 32'h0); // R3

  AST_PINS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(pin_oe) && $stable(pin_out)); // R5

  AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 12'h01C || reg_addr == 12'h124) |=> reg_rdata == 32'h0); // R8

  AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 12'h030 |=> reg_rdata == 32'h0 && $stable(pin_oe) && $stable(pin_out)); // R9
endmodule

bind gpio_bank_regfile gpio_bank_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_bank_regfile_test.sv
`timescale 1ns/1ps
module gpio_bank_regfile_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [11:0]  reg_addr;
  logic         reg_wr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic [127:0] pin_in;
  logic [127:0] pin_out;
  logic [127:0] pin_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0]  m_dir  [4];
  logic [31:0]  m_lat  [4];
  logic [31:0]  m_aflo [4];
  logic [31:0]  m_afhi [4];
  logic [127:0] m_pins;

  always #2 clk = ~clk;

  gpio_bank_regfile uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // kinds: 0 level, 1 dir, 2 set, 3 clear, 4 alt low, 5 alt high
  function automatic logic [11:0] addr_of(int kind, int b);
    case (kind)
      0: return (b == 3) ? 12'h100 : 12'(4 * b);
      1: return (b == 3) ? 12'h10C : 12'(12'h00C + 4 * b);
      2: return (b == 3) ? 12'h118 : 12'(12'h018 + 4 * b);
      3: return (b == 3) ? 12'h124 : 12'(12'h024 + 4 * b);
      4: return 12'(12'h054 + 8 * b);
      default: return 12'(12'h058 + 8 * b);
    endcase
  endfunction

  function automatic logic [31:0] exp_read(int kind, int b);
    case (kind)
      0: return (m_lat[b] & m_dir[b]) | (m_pins[b*32 +: 32] & ~m_dir[b]);
      1: return m_dir[b];
      4: return m_aflo[b];
      5: return m_afhi[b];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [11:0] unmapped(int i);
    case (i)
      0: return 12'h030;  1: return 12'h034;  2: return 12'h03C;
      3: return 12'h048;  4: return 12'h050;  5: return 12'h074;
      6: return 12'h0FC;  7: return 12'h104;  8: return 12'h130;
      9: return 12'h13C;  10: return 12'h148; 11: return 12'hFFC;
      default: return 12'h00E;
    endcase
  endfunction

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_pins(string req);
    logic [127:0] e_oe, e_out;
    for (int b = 0; b < 4; b++) begin
      e_oe[b*32 +: 32]  = m_dir[b];
      e_out[b*32 +: 32] = m_lat[b] & m_dir[b];
    end
    checks++;
    if (pin_oe !== e_oe || pin_out !== e_out) begin
      errors++;
      $display("FAIL %s: pin_oe %h pin_out %h expected %h %h", req, pin_oe, pin_out, e_oe, e_out);
    end
  endtask

  task automatic wr_reg(int kind, int b, logic [31:0] d);
    @(negedge clk);
    reg_addr = addr_of(kind, b); reg_wr = 1'b1; reg_wdata = d;
    @(posedge clk);
    case (kind)
      1: m_dir[b]  = d;
      2: m_lat[b]  = m_lat[b] | d;
      3: m_lat[b]  = m_lat[b] & ~d;
      4: m_aflo[b] = d;
      5: m_afhi[b] = d;
      default: ;
    endcase
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_raw(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, int kind, int b);
    @(negedge clk);
    reg_addr = addr_of(kind, b); reg_wr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check32(req, reg_rdata, exp_read(kind, b));
  endtask

  task automatic rd_all(string req);
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 6; k++) rd_chk(req, k, b);
  endtask

  task automatic set_pins(logic [127:0] v);
    @(negedge clk);
    pin_in = v; m_pins = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5EED));
    for (int b = 0; b < 4; b++) begin
      m_dir[b] = '0; m_lat[b] = '0; m_aflo[b] = '0; m_afhi[b] = '0;
    end
    m_pins = '0;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_pins("R1");
    rd_all("R1");

    // R2: direction in each bank, upper window for bank 3
    wr_reg(1, 3, 32'hA5A5_0F0F);
    rd_chk("R2", 1, 3);
    rd_chk("R2", 1, 0);
    check_pins("R2");
    for (int b = 0; b < 3; b++) wr_reg(1, b, 32'h1111_1111 << b);
    rd_all("R2");

    // R3, R5: set then clear, driven only where direction is output
    wr_reg(1, 0, 32'hFFFF_FFFF);
    wr_reg(2, 0, 32'hFFFF_0000);
    check_pins("R3");
    wr_reg(3, 0, 32'h0F0F_0000);
    check_pins("R3");
    rd_chk("R3", 0, 0);
    wr_reg(2, 3, 32'hFFFF_FFFF);
    check_pins("R5");
    wr_reg(3, 3, 32'h0000_00FF);
    check_pins("R3");
    rd_chk("R5", 0, 3);

    // R4: alternate-function words
    for (int b = 0; b < 4; b++) begin
      wr_reg(4, b, 32'hC0DE_0000 | b);
      wr_reg(5, b, 32'hBEEF_0000 | (b << 4));
    end
    for (int b = 0; b < 4; b++) begin
      rd_chk("R4", 4, b);
      rd_chk("R4", 5, b);
    end

    // R6: mixed level readback
    wr_reg(1, 1, 32'h0000_FFFF);
    wr_reg(2, 1, 32'hFFFF_FFFF);
    set_pins({32'hDEAD_BEEF, 32'h0F0F_F0F0, 32'h1234_5678, 32'h89AB_CDEF});
    for (int b = 0; b < 4; b++) rd_chk("R6", 0, b);

    // R7: synchronizer latency with the level address held
    wr_reg(1, 2, 32'h0);
    @(negedge clk);
    reg_addr = addr_of(0, 2);
    @(posedge clk);
    @(negedge clk);
    check32("R7", reg_rdata, m_pins[95:64]);
    pin_in[95:64] = ~m_pins[95:64];
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check32("R7", reg_rdata, m_pins[95:64]);
    @(posedge clk);
    @(negedge clk);
    check32("R7", reg_rdata, ~m_pins[95:64]);
    m_pins[95:64] = ~m_pins[95:64];

    // R8: set/clear read zero
    for (int b = 0; b < 4; b++) begin
      rd_chk("R8", 2, b);
      rd_chk("R8", 3, b);
    end

    // R9: unmapped offsets read zero, writes ignored
    for (int i = 0; i < 13; i++) begin
      wr_raw(unmapped(i), 32'hFFFF_FFFF);
      check_pins("R9");
      @(negedge clk);
      reg_addr = unmapped(i);
      @(posedge clk);
      @(negedge clk);
      check32("R9", reg_rdata, 32'h0);
    end
    rd_all("R9");

    // R10: read under a same-cycle write returns the old value
    @(negedge clk);
    reg_addr = addr_of(1, 0); reg_wr = 1'b1; reg_wdata = 32'h5A5A_A5A5;
    @(posedge clk);
    @(negedge clk);
    check32("R10", reg_rdata, m_dir[0]);
    m_dir[0] = 32'h5A5A_A5A5;
    reg_wr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check32("R10", reg_rdata, m_dir[0]);
    check_pins("R10");

    // random mix covering R2..R6, R8, R9
    for (int it = 0; it < 400; it++) begin
      int op, k, b;
      op = $urandom % 4;
      k  = $urandom % 6;
      b  = $urandom % 4;
      case (op)
        0: begin
          wr_reg((k == 0) ? 1 : k, b, $urandom);
          check_pins("R5");
        end
        1: rd_chk("R6", k, b);
        2: set_pins({$urandom, $urandom, $urandom, $urandom});
        default: begin
          wr_raw(unmapped($urandom % 13), $urandom);
          check_pins("R9");
        end
      endcase
    end
    rd_all("R6");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule